// File: doc/BRIEF.md
# LPC Peripheral Target Bridge

This block sits on the target side of a Low Pin Count bus. It watches an active-high frame strobe and the shared 4-bit address/data nibble bus. It decodes I/O, memory and firmware read and write cycles and turns each accepted cycle into exactly one request on a local register-style port. That request carries the address, direction, address space, byte count and write data, and it is closed by an acknowledge from the local side. While the request is outstanding the block holds the host in wait states with sync codes. Once the acknowledge arrives it signals ready or error, returns read data nibble by nibble and hands the bus back with a two-cycle turnaround.

An address window, set by the parameters `WIN_BASE` and `WIN_MASK`, selects the cycles the target claims. A cycle outside the window is followed silently, and the target never drives the bus for it. A new frame strobe at any point abandons the cycle in progress and withdraws any pending local request.

States and transitions: `ST_IDLE` (frame with 0000 goes to `ST_CTYPE`; frame with a firmware code goes to `ST_ADDR`). `ST_CTYPE` goes to `ST_ADDR`, or to `ST_SKIP` on an unsupported type. `ST_ADDR` loops until the last address nibble, then goes to `ST_SIZE` (firmware), `ST_HDATA` (write) or `ST_HTAR1` (read). `ST_SIZE` goes to `ST_HDATA` or `ST_HTAR1`, or to `ST_SKIP` on a bad size. `ST_HDATA` goes to `ST_HTAR1` after the last data nibble. `ST_HTAR1` goes to `ST_HTAR2`. `ST_HTAR2` goes to `ST_SWAIT` on a window hit and to `ST_SKIP` otherwise. `ST_SWAIT` goes to `ST_SDONE` on acknowledge. `ST_SDONE` goes to `ST_TDATA` (read without error) or `ST_TTAR1`. `ST_TDATA` goes to `ST_SDONE` between bytes and to `ST_TTAR1` after the last byte. `ST_TTAR1` goes to `ST_TTAR2`, and `ST_TTAR2` goes to `ST_IDLE`. A frame strobe overrides every state.

Top module: `lpc_target`

## Requirements
- R1: After reset the target does not drive the nibble bus (`lad_oe`=0) and `req_o` is low.
- R2: A cycle starts in a clock where `frame_i` is high. The bus nibble then selects the cycle: 0000 means memory or I/O, 1101 means firmware read, 1110 means firmware write. Any other nibble ends the cycle with no drive and no request.
- R3: For memory and I/O cycles the nibble after start is {0, is_memory, is_write, 0}. A type nibble with bit 3 or bit 0 set is ignored: no drive, no request. `req_we` reports the direction.
- R4: The address arrives most significant nibble first. Memory and firmware cycles carry 8 nibbles, I/O cycles carry 4, and the I/O address is zero-extended on `req_addr`. `req_space` is 00 for I/O, 01 for memory and 10 for firmware.
- R5: A firmware cycle carries a size nibble after the address: 0, 1 and 2 give 1, 2 and 4 bytes, and any other value ignores the cycle. Memory and I/O cycles move one byte. `req_nbytes` gives the count.
- R6: Write data arrives low nibble first, with bytes in ascending order, and is placed from bit 0 of `req_wdata`. Bytes not transferred read as zero.
- R7: A cycle is claimed only if ((address XOR WIN_BASE) AND WIN_MASK) is zero. Otherwise the target never drives the bus and raises no request.
- R8: The target never drives during the host's phases or the host turnaround. It first drives in the cycle after the host's float cycle. It ends with one cycle driving 1111 and one cycle floating, then returns to idle.
- R9: `req_o` rises in the first sync cycle and stays high until `ack_i` is sampled high, then drops. Each claimed cycle gives exactly one request.
- R10: While the request is outstanding the target drives 0101 (0110 when `LONG_WAIT`=1). In the cycle after the acknowledge it drives 0000.
- R11: On a read, the ready nibble is followed by the data captured from `rdata_i` at acknowledge, low nibble first. Every byte after the first is preceded by one 0000 sync nibble, and the turnaround follows the last byte. On a write, the turnaround follows the ready nibble.
- R12: If `err_i` is high with `ack_i`, the target drives 1010 in place of 0000 and goes straight to its turnaround without sending data.
- R13: A high `frame_i` in any cycle restarts decoding. `lad_oe` is low from the next cycle and any pending request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame strobe, active high |
| lad_i | input | 4 | Nibble bus as seen at the pins |
| lad_o | output | 4 | Nibble driven by the target |
| lad_oe | output | 1 | Registered drive enable for `lad_o` |
| req_o | output | 1 | Local request pending |
| req_we | output | 1 | Request is a write |
| req_space | output | 2 | 00 I/O, 01 memory, 10 firmware |
| req_addr | output | 32 | Decoded address |
| req_wdata | output | 32 | Write data, byte 0 in bits 7:0 |
| req_nbytes | output | 3 | Byte count: 1, 2 or 4 |
| ack_i | input | 1 | Local acknowledge, one cycle |
| err_i | input | 1 | Local error, valid with `ack_i` |
| rdata_i | input | 32 | Local read data, valid with `ack_i` |

## Verification
The decoder is driven with every cycle kind: I/O, memory and firmware, in both directions, and firmware at all three sizes. Comparing the captured request fields across these separates the address-width, direction and size decodes. Acknowledge latencies from zero to several cycles, and multi-byte reads, show that the wait count, the inter-byte ready nibbles and the nibble order follow the local handshake and not a fixed schedule. Out-of-window addresses, bad start, type and size nibbles, an error acknowledge and a mid-wait frame strobe each check a different exit from the normal path, by watching that the bus stays undriven and that no request is raised.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    localparam int LAD_W    = 4;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_NIB = ADDR_W / LAD_W;
    localparam int IO_NIB   = 4;
    localparam int DATA_NIB = DATA_W / LAD_W;
    localparam int ACNT_W   = $clog2(ADDR_NIB);
    localparam int DCNT_W   = $clog2(DATA_NIB);
    localparam int NB_W     = $clog2(DATA_W / 8) + 1;

    localparam logic [3:0] NIB_START = 4'b0000;
    localparam logic [3:0] NIB_FWRD  = 4'b1101;
    localparam logic [3:0] NIB_FWWR  = 4'b1110;
    localparam logic [3:0] NIB_TAR   = 4'b1111;
    localparam logic [3:0] SYN_READY = 4'b0000;
    localparam logic [3:0] SYN_SHORT = 4'b0101;
    localparam logic [3:0] SYN_LONG  = 4'b0110;
    localparam logic [3:0] SYN_ERR   = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CTYPE, ST_ADDR, ST_SIZE, ST_HDATA, ST_HTAR1, ST_HTAR2,
        ST_SWAIT, ST_SDONE, ST_TDATA, ST_TTAR1, ST_TTAR2, ST_SKIP
    } tstate_t;

    typedef enum logic [1:0] {
        SP_IO  = 2'b00,
        SP_MEM = 2'b01,
        SP_FW  = 2'b10
    } space_t;

endpackage

// File: rtl/lpc_tgt_window.sv
module lpc_tgt_window
    import lpc_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] MASK = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    genvar g;
    generate
        for (g = 0; g < ADDR_W; g++) begin : g_bit
            assign diff[g] = (addr[g] ^ BASE[g]) & MASK[g];
        end
    endgenerate

    assign hit = (diff == '0);

endmodule

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
    import lpc_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [LAD_W-1:0]  lad_i,
    input  logic              win_hit,
    input  logic              ack_i,
    input  logic              err_i,
    input  logic [DATA_W-1:0] rdata_i,
    output tstate_t           state_o,
    output tstate_t           nxt_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              we_o,
    output logic [1:0]        space_o,
    output logic [NB_W-1:0]   nbytes_o,
    output logic              req_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DCNT_W-1:0] nib_o
);
    tstate_t           state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [ACNT_W-1:0] acnt, alast;
    logic [DCNT_W-1:0] dcnt;
    logic [NB_W-1:0]   nbytes_q;
    logic [DCNT_W:0]   dlast;
    logic              dcnt_end;
    logic              we_q, req_q, err_q;
    space_t            space_q;

    assign dlast    = {nbytes_q, 1'b0} - 1'b1;
    assign dcnt_end = ({1'b0, dcnt} == dlast);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (frame_i) begin
            if (lad_i == NIB_START)                          nxt = ST_CTYPE;
            else if (lad_i == NIB_FWRD || lad_i == NIB_FWWR) nxt = ST_ADDR;
            else                                             nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_SKIP:  nxt = ST_SKIP;
                ST_CTYPE: nxt = (lad_i[3] | lad_i[0]) ? ST_SKIP : ST_ADDR;
                ST_ADDR:
                    if (acnt == alast)
                        nxt = (space_q == SP_FW) ? ST_SIZE : (we_q ? ST_HDATA : ST_HTAR1);
                ST_SIZE:  nxt = (lad_i > 4'd2) ? ST_SKIP : (we_q ? ST_HDATA : ST_HTAR1);
                ST_HDATA: if (dcnt_end) nxt = ST_HTAR1;
                ST_HTAR1: nxt = ST_HTAR2;
                ST_HTAR2: nxt = win_hit ? ST_SWAIT : ST_SKIP;
                ST_SWAIT: if (ack_i) nxt = ST_SDONE;
                ST_SDONE: nxt = (!we_q && !err_q) ? ST_TDATA : ST_TTAR1;
                ST_TDATA: if (dcnt[0]) nxt = dcnt_end ? ST_TTAR1 : ST_SDONE;
                ST_TTAR1: nxt = ST_TTAR2;
                ST_TTAR2: nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // decode datapath and local request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            acnt     <= '0;
            alast    <= '0;
            dcnt     <= '0;
            nbytes_q <= NB_W'(1);
            we_q     <= 1'b0;
            req_q    <= 1'b0;
            err_q    <= 1'b0;
            space_q  <= SP_IO;
        end else if (frame_i) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            acnt     <= '0;
            dcnt     <= '0;
            nbytes_q <= NB_W'(1);
            req_q    <= 1'b0;
            err_q    <= 1'b0;
            if (lad_i == NIB_FWRD || lad_i == NIB_FWWR) begin
                space_q <= SP_FW;
                we_q    <= (lad_i == NIB_FWWR);
                alast   <= ACNT_W'(ADDR_NIB - 1);
            end
        end else begin
            unique case (state)
                ST_CTYPE: begin
                    space_q <= lad_i[2] ? SP_MEM : SP_IO;
                    we_q    <= lad_i[1];
                    alast   <= lad_i[2] ? ACNT_W'(ADDR_NIB - 1) : ACNT_W'(IO_NIB - 1);
                end
                ST_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-LAD_W-1:0], lad_i};
                    acnt   <= acnt + 1'b1;
                end
                ST_SIZE:
                    nbytes_q <= (lad_i == 4'd1) ? NB_W'(2) :
                                (lad_i == 4'd2) ? NB_W'(4) : NB_W'(1);
                ST_HDATA: begin
                    wdata_q[{dcnt, 2'b00} +: LAD_W] <= lad_i;
                    dcnt <= dcnt_end ? '0 : dcnt + 1'b1;
                end
                ST_HTAR2: req_q <= win_hit;
                ST_SWAIT:
                    if (ack_i) begin
                        req_q   <= 1'b0;
                        err_q   <= err_i;
                        rdata_q <= rdata_i;
                    end
                ST_TDATA: dcnt <= dcnt + 1'b1;
                default: ;
            endcase
        end
    end

    assign state_o  = state;
    assign nxt_o    = nxt;
    assign addr_o   = addr_q;
    assign wdata_o  = wdata_q;
    assign we_o     = we_q;
    assign space_o  = space_q;
    assign nbytes_o = nbytes_q;
    assign req_o    = req_q;
    assign err_o    = err_q;
    assign rdata_o  = rdata_q;
    assign nib_o    = dcnt;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && !ack_i && !frame_i |=> req_q);                          // R9
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && ack_i |=> !req_q);                                      // R9
    AST_REQ_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(state) == ST_HTAR2 && $past(win_hit));    // R7
    AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> !req_q);                                             // R13

endmodule

// File: rtl/lpc_tgt_lad.sv
module lpc_tgt_lad
    import lpc_tgt_pkg::*;
#(
    parameter bit LONG_WAIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tstate_t           state,
    input  tstate_t           nxt,
    input  logic              err_q,
    input  logic [DATA_W-1:0] rdata_q,
    input  logic [DCNT_W-1:0] nib,
    output logic [LAD_W-1:0]  lad_o,
    output logic              lad_oe
);
    logic [LAD_W-1:0] wait_code;

    generate
        if (LONG_WAIT) begin : g_long
            assign wait_code = SYN_LONG;
        end else begin : g_short
            assign wait_code = SYN_SHORT;
        end
    endgenerate

    // registered drive enable, set for the states the target owns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lad_oe <= 1'b0;
        else        lad_oe <= (nxt inside {ST_SWAIT, ST_SDONE, ST_TDATA, ST_TTAR1});
    end

    always_comb begin
        unique case (state)
            ST_SWAIT: lad_o = wait_code;
            ST_SDONE: lad_o = err_q ? SYN_ERR : SYN_READY;
            ST_TDATA: lad_o = rdata_q[{nib, 2'b00} +: LAD_W];
            default:  lad_o = NIB_TAR;
        endcase
    end

    AST_HOST_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_IDLE, ST_CTYPE, ST_ADDR, ST_SIZE, ST_HDATA,
                       ST_HTAR1, ST_HTAR2, ST_SKIP}) |-> !lad_oe);       // R8
    AST_TAR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TTAR1 |-> lad_oe && lad_o == NIB_TAR);               // R8
    AST_TAR_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TTAR2 |-> !lad_oe);                                  // R8

endmodule

// File: rtl/lpc_target.sv
module lpc_target
    import lpc_tgt_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'h0000_0080,
    parameter logic [31:0] WIN_MASK  = 32'hFFFF_FFF0,
    parameter bit          LONG_WAIT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_i,
    input  logic [3:0]  lad_i,
    output logic [3:0]  lad_o,
    output logic        lad_oe,
    output logic        req_o,
    output logic        req_we,
    output logic [1:0]  req_space,
    output logic [31:0] req_addr,
    output logic [31:0] req_wdata,
    output logic [2:0]  req_nbytes,
    input  logic        ack_i,
    input  logic        err_i,
    input  logic [31:0] rdata_i
);
    tstate_t           state, nxt;
    logic              hit, err_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DCNT_W-1:0] nib;

    lpc_tgt_window #(.BASE(WIN_BASE), .MASK(WIN_MASK)) u_win (
        .addr (req_addr),
        .hit  (hit)
    );

    lpc_tgt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_i  (frame_i),
        .lad_i    (lad_i),
        .win_hit  (hit),
        .ack_i    (ack_i),
        .err_i    (err_i),
        .rdata_i  (rdata_i),
        .state_o  (state),
        .nxt_o    (nxt),
        .addr_o   (req_addr),
        .wdata_o  (req_wdata),
        .we_o     (req_we),
        .space_o  (req_space),
        .nbytes_o (req_nbytes),
        .req_o    (req_o),
        .err_o    (err_q),
        .rdata_o  (rdata_q),
        .nib_o    (nib)
    );

    lpc_tgt_lad #(.LONG_WAIT(LONG_WAIT)) u_lad (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .nxt     (nxt),
        .err_q   (err_q),
        .rdata_q (rdata_q),
        .nib     (nib),
        .lad_o   (lad_o),
        .lad_oe  (lad_oe)
    );

endmodule

// File: tb/tb_lpc_target.sv
module tb_lpc_target;

    logic        clk = 1'b0;
    logic        rst_n, frame_i, host_oe, ack_i, err_i;
    logic [3:0]  host_lad, lad_o, lad_i;
    logic        lad_oe, req_o, req_we;
    logic [1:0]  req_space;
    logic [31:0] req_addr, req_wdata, rdata_i;
    logic [2:0]  req_nbytes;

    always #5 clk = ~clk;

    assign lad_i = host_oe ? host_lad : (lad_oe ? lad_o : 4'hF);

    lpc_target dut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .lad_i(lad_i),
        .lad_o(lad_o), .lad_oe(lad_oe), .req_o(req_o), .req_we(req_we),
        .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_nbytes(req_nbytes), .ack_i(ack_i), .err_i(err_i), .rdata_i(rdata_i)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // local responder model
    int          rsp_lat = 0, rsp_cnt = 0, nreq = 0;
    bit          rsp_err = 0;
    logic [31:0] rsp_data = '0;
    logic [31:0] cap_addr, cap_wdata;
    logic        cap_we;
    logic [1:0]  cap_sp;
    logic [2:0]  cap_nb;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (ack_i) begin
            ack_i = 1'b0;
            rsp_cnt = 0;
        end else if (req_o) begin
            if (rsp_cnt == rsp_lat) begin
                ack_i = 1'b1; err_i = rsp_err; rdata_i = rsp_data; nreq++;
                cap_addr = req_addr; cap_wdata = req_wdata; cap_we = req_we;
                cap_sp = req_space; cap_nb = req_nbytes;
            end else rsp_cnt++;
        end else rsp_cnt = 0;
    end

    // one bus cycle: compare the target's side, then drive the host's side
    task automatic tick(input bit fr, input bit hoe, input logic [3:0] hl,
                        input bit eoe, input logic [3:0] el, input string r);
        @(negedge clk);
        chk(lad_oe == eoe, {r, " oe"}, 32'(lad_oe), 32'(eoe));
        if (eoe) chk(lad_o == el, {r, " lad"}, 32'(lad_o), 32'(el));
        frame_i = fr; host_oe = hoe; host_lad = hl;
    endtask

    // kind: 0 I/O, 1 memory, 2 firmware
    task automatic xfer(input int kind, input bit we, input logic [31:0] addr,
                        input logic [3:0] szc, input logic [31:0] wd, input int lat,
                        input bit err, input bit hit, input logic [31:0] rd, input bit nostart);
        int nb, an, base;
        logic [31:0] msk, eaddr;
        base = nreq;
        rsp_lat = lat; rsp_err = err; rsp_data = rd;
        nb = (kind == 2) ? ((szc == 1) ? 2 : (szc == 2) ? 4 : 1) : 1;
        an = (kind == 0) ? 4 : 8;
        msk = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1);
        eaddr = (kind == 0) ? {16'h0, addr[15:0]} : addr;
        if (!nostart) tick(1, 1, (kind == 2) ? (we ? 4'hE : 4'hD) : 4'h0, 0, 4'h0, "R2");
        if (kind != 2) tick(0, 1, {1'b0, kind == 1, we, 1'b0}, 0, 4'h0, "R3");
        if (nostart) chk(req_o == 1'b0, "R13 req withdrawn", 32'(req_o), 0);
        for (int i = an - 1; i >= 0; i--) tick(0, 1, addr[i*4 +: 4], 0, 4'h0, "R4");
        if (kind == 2) tick(0, 1, szc, 0, 4'h0, "R5");
        if (we) for (int i = 0; i < nb * 2; i++) tick(0, 1, wd[i*4 +: 4], 0, 4'h0, "R6");
        tick(0, 1, 4'hF, 0, 4'h0, "R8 host tar1");
        tick(0, 0, 4'h0, 0, 4'h0, "R8 host tar2");
        if (!hit) begin
            for (int i = 0; i < 6; i++) tick(0, 0, 4'h0, 0, 4'h0, "R7 no drive");
            chk(nreq == base, "R7 no request", 32'(nreq), 32'(base));
            return;
        end
        for (int i = 0; i <= lat; i++) begin
            tick(0, 0, 4'h0, 1, 4'h5, "R10 wait");
            if (i == 0) chk(req_o == 1'b1, "R9 req raised", 32'(req_o), 1);
        end
        tick(0, 0, 4'h0, 1, err ? 4'hA : 4'h0, err ? "R12 error sync" : "R10 ready");
        chk(req_o == 1'b0, "R9 req dropped", 32'(req_o), 0);
        if (!we && !err)
            for (int b = 0; b < nb; b++) begin
                if (b > 0) tick(0, 0, 4'h0, 1, 4'h0, "R11 inter-byte sync");
                for (int n = 0; n < 2; n++) tick(0, 0, 4'h0, 1, rd[b*8 + n*4 +: 4], "R11 data");
            end
        tick(0, 0, 4'h0, 1, 4'hF, "R8 target tar1");
        tick(0, 0, 4'h0, 0, 4'h0, "R8 target tar2");
        tick(0, 0, 4'h0, 0, 4'h0, "R8 idle");
        chk(nreq == base + 1, "R9 one request", 32'(nreq), 32'(base + 1));
        chk(cap_addr == eaddr, "R4 address", cap_addr, eaddr);
        chk(cap_we == we, "R3 direction", 32'(cap_we), 32'(we));
        chk(cap_sp == 2'(kind), "R4 space", 32'(cap_sp), 32'(kind));
        chk(32'(cap_nb) == 32'(nb), "R5 byte count", 32'(cap_nb), 32'(nb));
        if (we) chk(cap_wdata == (wd & msk), "R6 write data", cap_wdata, wd & msk);
    endtask

    task automatic ignored(input logic [3:0] n0, input logic [3:0] n1, input string r);
        int base;
        base = nreq;
        tick(1, 1, n0, 0, 4'h0, r);
        tick(0, 1, n1, 0, 4'h0, r);
        for (int i = 0; i < 12; i++) tick(0, 1, 4'h0, 0, 4'h0, r);
        for (int i = 0; i < 6; i++) tick(0, 0, 4'h0, 0, 4'h0, r);
        chk(nreq == base, {r, " no request"}, 32'(nreq), 32'(base));
    endtask

    initial begin
        rst_n = 0; frame_i = 0; host_oe = 0; host_lad = 0;
        ack_i = 0; err_i = 0; rdata_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(lad_oe == 0, "R1 reset oe", 32'(lad_oe), 0);
        chk(req_o == 0, "R1 reset req", 32'(req_o), 0);

        xfer(0, 1, 32'h0000_0085, 0, 32'h0000_005A, 0, 0, 1, 0, 0);
        xfer(0, 0, 32'h0000_008C, 0, 0, 2, 0, 1, 32'h0000_00C3, 0);
        xfer(1, 0, 32'h0000_0081, 0, 0, 1, 0, 1, 32'h0000_00A7, 0);
        xfer(1, 1, 32'h0000_008F, 0, 32'hFFFF_FF3C, 3, 0, 1, 0, 0);
        xfer(2, 0, 32'h0000_0088, 2, 0, 0, 0, 1, 32'h1234_5678, 0);
        xfer(2, 1, 32'h0000_0080, 1, 32'h55AA_BEEF, 1, 0, 1, 0, 0);
        xfer(2, 0, 32'h0000_008A, 0, 0, 4, 0, 1, 32'h0000_0096, 0);
        xfer(0, 0, 32'h0000_0090, 0, 0, 0, 0, 0, 0, 0);          // R7 miss
        xfer(1, 1, 32'h1000_0080, 0, 32'h11, 0, 0, 0, 0, 0);      // R7 miss
        xfer(0, 0, 32'h0000_0082, 0, 0, 1, 1, 1, 32'h0000_00EE, 0); // R12
        xfer(2, 0, 32'h0000_0084, 2, 0, 0, 1, 1, 32'hDEAD_BEEF, 0); // R12

        ignored(4'h3, 4'h0, "R2 bad start");
        ignored(4'h0, 4'h8, "R3 bad type");
        ignored(4'h0, 4'h3, "R3 bad type");

        // R5: firmware read with an unsupported size nibble
        begin
            int base;
            base = nreq;
            tick(1, 1, 4'hD, 0, 4'h0, "R5 bad size");
            for (int i = 0; i < 7; i++) tick(0, 1, 4'h0, 0, 4'h0, "R5 bad size");
            tick(0, 1, 4'h8, 0, 4'h0, "R5 bad size");
            tick(0, 1, 4'h3, 0, 4'h0, "R5 bad size");
            tick(0, 1, 4'hF, 0, 4'h0, "R5 bad size");
            for (int i = 0; i < 6; i++) tick(0, 0, 4'h0, 0, 4'h0, "R5 bad size");
            chk(nreq == base, "R5 bad size no request", 32'(nreq), 32'(base));
        end

        // R13: frame strobe during a long wait, then a fresh I/O write
        rsp_lat = 20;
        tick(1, 1, 4'h0, 0, 4'h0, "R13");
        tick(0, 1, 4'h0, 0, 4'h0, "R13");
        for (int i = 3; i >= 0; i--) tick(0, 1, (16'h0086 >> (i * 4)) & 4'hF, 0, 4'h0, "R13");
        tick(0, 1, 4'hF, 0, 4'h0, "R13");
        tick(0, 0, 4'h0, 0, 4'h0, "R13");
        for (int i = 0; i < 3; i++) tick(0, 0, 4'h0, 1, 4'h5, "R13 wait");
        tick(1, 1, 4'h0, 1, 4'h5, "R13 abort cycle");
        xfer(0, 1, 32'h0000_0087, 0, 32'h0000_0042, 0, 0, 1, 0, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule